// File: doc/BRIEF.md
# Stepped FMCW Frequency Ramp Generator

This block produces a signed frequency offset that a fractional-N synthesizer adds to its fractional word, so that the synthesized carrier walks through a staircase chirp. It runs on the phase-detector clock. A step timer decides when each step lands. At every step the block adds or removes one increment. The increment is a signed 16-bit deviation word shifted left by a 4-bit power-of-two exponent. Sawtooth and triangular sweeps are available. A second rate set can follow the first inside one sweep, and a frequency-shift-keying deviation can be laid over the ramp on alternate steps.

Software writes a small register file through a synchronous write port. These writes go to shadow copies, and a sweep only picks them up at a clean point, so a running chirp never mixes old and new settings. A level `start` arms the generator and clears it when it drops. `enable` pauses the step timer without losing the sweep position. The outputs are the offset word, a one-cycle strobe for each applied step, and a flag that marks the last step of each sweep.

Top module: `step_ramp_gen`

## Requirements
- R1: While `rstN` is low, and after reset before any start, `offsetOut` is 0 and `stepStrobe` and `sweepDone` are low.
- R2: Step period is P = max(1,div1) × max(1,div2) clock cycles, with div1 in bits [11:0] and div2 in bits [27:16] of address 4. The first step lands on the P-th rising edge after the edge that first samples `start` high. `stepStrobe` is high for the cycle right after each step lands, and `offsetOut` changes only at those steps or when `start` is low.
- R3: The increment of a rate set is its signed 16-bit deviation word (bits [15:0] of address 0 for set A, address 2 for set B) sign-extended and shifted left by its exponent (bits [19:16] of the same register).
- R4: Mode 0 in bits [1:0] of address 4+1 (address 5) selects sawtooth. The up-leg takes N steps, where N comes from bits [19:0] of address 1 and a value of 0 counts as 1. The following step returns the offset to 0 and raises `sweepDone`, and the sweep then repeats.
- R5: Mode 1 selects triangle. The offset makes N up steps and then N down steps with the same increment, ending at 0. `sweepDone` rises on the last down step.
- R6: With bit 2 of address 5 set (two rates), set A runs its N_A up steps and then set B (step count in address 3) runs N_B up steps. Triangle descends with set B for N_B steps and then with set A for N_A steps. Sawtooth returns to 0 after both legs.
- R7: With bit 3 of address 5 set, an FSK increment (word and exponent at address 6, same layout as R3) is switched on and off at successive steps, starting on at the first step. It is added to the output while on and never changes the ramp accumulator.
- R8: The accumulator and the output saturate at the 32-bit signed limits instead of wrapping.
- R9: When `start` is sampled low, `offsetOut` is 0 and there are no strobes from the next cycle on.
- R10: Register writes are held in shadow copies. They take effect only on a rising `start` or at the step that ends a sweep.
- R11: While `enable` is low, the step timer halts, no step is applied and `offsetOut` holds. On resume, the sweep continues from where it stopped.
- R12: Modes 2 and 3 hold the generator idle: no steps and an offset of 0 while started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase-detector rate clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 3 | Configuration register address |
| cfgData | input | 32 | Configuration write data |
| start | input | 1 | Arms the sweep while high, clears it while low |
| enable | input | 1 | Lets the step timer run while high |
| offsetOut | output | 32 | Signed frequency offset word |
| stepStrobe | output | 1 | One-cycle pulse after each applied step |
| sweepDone | output | 1 | Pulse with the strobe of the final step of a sweep |

## Verification
On every cycle, the properties check four things. A stop clears the output and silences the strobes on the next cycle. The offset never moves except at a step or a clear. A paused timer produces no step. The end-of-sweep flag only appears together with a step strobe. The bench scenarios cover what needs a whole sweep to see: the exact staircase values for each mode and each rate combination, the FSK pattern, clipping at both signed limits, the step period in cycles, and the delayed adoption of shadowed writes.

// File: rtl/ramp_pkg.sv
package ramp_pkg;

  localparam logic [1:0] MODE_SAW = 2'd0;
  localparam logic [1:0] MODE_TRI = 2'd1;

  localparam int REG_DEV_BASE   = 0;   // set g deviation at 2*g
  localparam int REG_STEP_BASE  = 1;   // set g step count at 2*g+1
  localparam int REG_TIMER      = 4;
  localparam int REG_CTRL       = 5;
  localparam int REG_FSK        = 6;

  localparam int SHIFT_LSB = 16;
  localparam int DIV2_LSB  = 16;

  typedef enum logic [2:0] {
    PH_UP_A,
    PH_UP_B,
    PH_DN_B,
    PH_DN_A,
    PH_RETURN
  } rampPhase_e;

  typedef struct packed {
    logic clear;     // start low: zero everything
    logic apply;     // a step lands this edge
    logic subtract;  // descending leg
    logic useB;      // second rate set
    logic toZero;    // sawtooth return step
  } ctlStrobe_t;

endpackage

// File: rtl/ramp_cfg.sv
module ramp_cfg
  import ramp_pkg::*;
#(
  parameter int DEV_W   = 16,
  parameter int SHIFT_W = 4,
  parameter int STEP_W  = 20,
  parameter int DIV_W   = 12,
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWe,
  input  logic [ADDR_W-1:0]   cfgAddr,
  input  logic [DATA_W-1:0]   cfgData,
  input  logic                loadCfg,
  output logic [DEV_W-1:0]    actDev [2],
  output logic [SHIFT_W-1:0]  actShift [2],
  output logic [STEP_W-1:0]   actSteps [2],
  output logic [DIV_W-1:0]    actDiv1,
  output logic [DIV_W-1:0]    actDiv2,
  output logic [1:0]          actMode,
  output logic                actDual,
  output logic                actFsk,
  output logic [DEV_W-1:0]    actFskDev,
  output logic [SHIFT_W-1:0]  actFskShift
);

  localparam int NUM_SETS = 2;

  for (genvar g = 0; g < NUM_SETS; g++) begin : gSet
    localparam logic [ADDR_W-1:0] DEV_ADDR  = ADDR_W'(REG_DEV_BASE + 2 * g);
    localparam logic [ADDR_W-1:0] STEP_ADDR = ADDR_W'(REG_STEP_BASE + 2 * g);

    logic [DEV_W-1:0]   shDev,   acDev;
    logic [SHIFT_W-1:0] shShift, acShift;
    logic [STEP_W-1:0]  shSteps, acSteps;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        shDev   <= '0;
        shShift <= '0;
        shSteps <= '0;
      end else if (cfgWe) begin
        if (cfgAddr == DEV_ADDR) begin
          shDev   <= cfgData[DEV_W-1:0];
          shShift <= cfgData[SHIFT_LSB +: SHIFT_W];
        end
        if (cfgAddr == STEP_ADDR) shSteps <= cfgData[STEP_W-1:0];
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        acDev   <= '0;
        acShift <= '0;
        acSteps <= '0;
      end else if (loadCfg) begin
        acDev   <= shDev;
        acShift <= shShift;
        acSteps <= shSteps;
      end
    end

    assign actDev[g]   = acDev;
    assign actShift[g] = acShift;
    assign actSteps[g] = acSteps;
  end

  logic [DIV_W-1:0]   shDiv1, shDiv2;
  logic [1:0]         shMode;
  logic               shDual, shFsk;
  logic [DEV_W-1:0]   shFskDev;
  logic [SHIFT_W-1:0] shFskShift;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shDiv1     <= '0;
      shDiv2     <= '0;
      shMode     <= MODE_SAW;
      shDual     <= 1'b0;
      shFsk      <= 1'b0;
      shFskDev   <= '0;
      shFskShift <= '0;
    end else if (cfgWe) begin
      case (cfgAddr)
        ADDR_W'(REG_TIMER): begin
          shDiv1 <= cfgData[DIV_W-1:0];
          shDiv2 <= cfgData[DIV2_LSB +: DIV_W];
        end
        ADDR_W'(REG_CTRL): begin
          shMode <= cfgData[1:0];
          shDual <= cfgData[2];
          shFsk  <= cfgData[3];
        end
        ADDR_W'(REG_FSK): begin
          shFskDev   <= cfgData[DEV_W-1:0];
          shFskShift <= cfgData[SHIFT_LSB +: SHIFT_W];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actDiv1     <= '0;
      actDiv2     <= '0;
      actMode     <= MODE_SAW;
      actDual     <= 1'b0;
      actFsk      <= 1'b0;
      actFskDev   <= '0;
      actFskShift <= '0;
    end else if (loadCfg) begin
      actDiv1     <= shDiv1;
      actDiv2     <= shDiv2;
      actMode     <= shMode;
      actDual     <= shDual;
      actFsk      <= shFsk;
      actFskDev   <= shFskDev;
      actFskShift <= shFskShift;
    end
  end

endmodule

// File: rtl/ramp_ctl.sv
module ramp_ctl
  import ramp_pkg::*;
#(
  parameter int STEP_W = 20,
  parameter int DIV_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              enable,
  input  logic [1:0]        mode,
  input  logic              dual,
  input  logic [STEP_W-1:0] steps [2],
  input  logic [DIV_W-1:0]  div1,
  input  logic [DIV_W-1:0]  div2,
  output ctlStrobe_t        strb,
  output logic              loadCfg,
  output logic              stepStrobe,
  output logic              sweepDone
);

  localparam int TMR_W = 2 * DIV_W;

  logic             startQ;
  logic             armed;
  logic             modeRun;
  logic             isTri;
  logic [DIV_W-1:0] d1Eff, d2Eff;
  logic [TMR_W-1:0] period;
  logic [TMR_W-1:0] timerCnt;
  logic             timerHit;
  logic             tick;
  rampPhase_e       phase, nextPhase;
  logic [STEP_W-1:0] stepIdx;
  logic [STEP_W-1:0] curSteps, effSteps;
  logic             lastInPhase;
  logic             sweepEnd;

  assign armed   = start && startQ;
  assign isTri   = (mode == MODE_TRI);
  assign modeRun = (mode == MODE_SAW) || isTri;

  assign d1Eff    = (div1 == '0) ? DIV_W'(1) : div1;
  assign d2Eff    = (div2 == '0) ? DIV_W'(1) : div2;
  assign period   = TMR_W'(d1Eff) * TMR_W'(d2Eff);
  assign timerHit = (timerCnt >= period - TMR_W'(1));
  assign tick     = armed && enable && modeRun && timerHit;

  assign curSteps    = (phase == PH_UP_B || phase == PH_DN_B) ? steps[1] : steps[0];
  assign effSteps    = (curSteps == '0) ? STEP_W'(1) : curSteps;
  assign lastInPhase = (phase == PH_RETURN) || (stepIdx == effSteps - STEP_W'(1));
  assign sweepEnd    = tick && lastInPhase && (phase == PH_DN_A || phase == PH_RETURN);

  always_comb begin
    case (phase)
      PH_UP_A: nextPhase = dual ? PH_UP_B : (isTri ? PH_DN_A : PH_RETURN);
      PH_UP_B: nextPhase = isTri ? PH_DN_B : PH_RETURN;
      PH_DN_B: nextPhase = PH_DN_A;
      default: nextPhase = PH_UP_A;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) startQ <= 1'b0;
    else       startQ <= start;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !armed) begin
      timerCnt <= '0;
      phase    <= PH_UP_A;
      stepIdx  <= '0;
    end else if (enable && modeRun) begin
      if (timerHit) begin
        timerCnt <= '0;
        if (lastInPhase) begin
          phase   <= nextPhase;
          stepIdx <= '0;
        end else begin
          stepIdx <= stepIdx + STEP_W'(1);
        end
      end else begin
        timerCnt <= timerCnt + TMR_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepStrobe <= 1'b0;
      sweepDone  <= 1'b0;
    end else begin
      stepStrobe <= tick;
      sweepDone  <= sweepEnd;
    end
  end

  assign loadCfg = (start && !startQ) || sweepEnd;

  always_comb begin
    strb.clear    = !start;
    strb.apply    = tick;
    strb.subtract = (phase == PH_DN_A) || (phase == PH_DN_B);
    strb.useB     = (phase == PH_UP_B) || (phase == PH_DN_B);
    strb.toZero   = (phase == PH_RETURN);
  end

endmodule

// File: rtl/ramp_dp.sv
module ramp_dp
  import ramp_pkg::*;
#(
  parameter int DEV_W   = 16,
  parameter int SHIFT_W = 4,
  parameter int ACC_W   = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strb,
  input  logic [DEV_W-1:0]   dev [2],
  input  logic [SHIFT_W-1:0] shift [2],
  input  logic               fskEn,
  input  logic [DEV_W-1:0]   fskDev,
  input  logic [SHIFT_W-1:0] fskShift,
  output logic [ACC_W-1:0]   offsetOut
);

  localparam logic [ACC_W-1:0] SAT_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] SAT_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  function automatic logic [ACC_W-1:0] scaleDev(input logic [DEV_W-1:0] w,
                                                 input logic [SHIFT_W-1:0] s);
    logic signed [ACC_W-1:0] ext;
    ext = signed'({{(ACC_W-DEV_W){w[DEV_W-1]}}, w});
    return ext <<< s;
  endfunction

  function automatic logic [ACC_W-1:0] clip(input logic [ACC_W:0] s);
    if (s[ACC_W] != s[ACC_W-1]) return s[ACC_W] ? SAT_MIN : SAT_MAX;
    return s[ACC_W-1:0];
  endfunction

  function automatic logic [ACC_W-1:0] satAdd(input logic [ACC_W-1:0] a,
                                               input logic [ACC_W-1:0] b);
    return clip({a[ACC_W-1], a} + {b[ACC_W-1], b});
  endfunction

  function automatic logic [ACC_W-1:0] satSub(input logic [ACC_W-1:0] a,
                                               input logic [ACC_W-1:0] b);
    return clip({a[ACC_W-1], a} - {b[ACC_W-1], b});
  endfunction

  logic [ACC_W-1:0] incSet [2];
  logic [ACC_W-1:0] inc, fskInc, acc;
  logic             fskOn;

  for (genvar g = 0; g < 2; g++) begin : gInc
    assign incSet[g] = scaleDev(dev[g], shift[g]);
  end

  assign inc    = strb.useB ? incSet[1] : incSet[0];
  assign fskInc = scaleDev(fskDev, fskShift);

  always_ff @(posedge clk) begin
    if (!rstN || strb.clear) begin
      acc   <= '0;
      fskOn <= 1'b0;
    end else if (strb.apply) begin
      if (strb.toZero)        acc <= '0;
      else if (strb.subtract) acc <= satSub(acc, inc);
      else                    acc <= satAdd(acc, inc);
      fskOn <= fskEn && !fskOn;
    end
  end

  assign offsetOut = satAdd(acc, fskOn ? fskInc : '0);

endmodule

// File: rtl/step_ramp_gen.sv
module step_ramp_gen
  import ramp_pkg::*;
#(
  parameter int DEV_W   = 16,
  parameter int SHIFT_W = 4,
  parameter int STEP_W  = 20,
  parameter int DIV_W   = 12,
  parameter int ACC_W   = 32,
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [DATA_W-1:0] cfgData,
  input  logic              start,
  input  logic              enable,
  output logic [ACC_W-1:0]  offsetOut,
  output logic              stepStrobe,
  output logic              sweepDone
);

  logic [DEV_W-1:0]   actDev [2];
  logic [SHIFT_W-1:0] actShift [2];
  logic [STEP_W-1:0]  actSteps [2];
  logic [DIV_W-1:0]   actDiv1, actDiv2;
  logic [1:0]         actMode;
  logic               actDual, actFsk;
  logic [DEV_W-1:0]   actFskDev;
  logic [SHIFT_W-1:0] actFskShift;
  logic               loadCfg;
  ctlStrobe_t         strb;

  ramp_cfg #(
    .DEV_W(DEV_W), .SHIFT_W(SHIFT_W), .STEP_W(STEP_W),
    .DIV_W(DIV_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_cfg (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .loadCfg(loadCfg), .actDev(actDev), .actShift(actShift), .actSteps(actSteps),
    .actDiv1(actDiv1), .actDiv2(actDiv2), .actMode(actMode), .actDual(actDual),
    .actFsk(actFsk), .actFskDev(actFskDev), .actFskShift(actFskShift)
  );

  ramp_ctl #(.STEP_W(STEP_W), .DIV_W(DIV_W)) u_ctl (
    .clk(clk), .rstN(rstN), .start(start), .enable(enable), .mode(actMode),
    .dual(actDual), .steps(actSteps), .div1(actDiv1), .div2(actDiv2),
    .strb(strb), .loadCfg(loadCfg), .stepStrobe(stepStrobe), .sweepDone(sweepDone)
  );

  ramp_dp #(.DEV_W(DEV_W), .SHIFT_W(SHIFT_W), .ACC_W(ACC_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .dev(actDev), .shift(actShift),
    .fskEn(actFsk), .fskDev(actFskDev), .fskShift(actFskShift), .offsetOut(offsetOut)
  );

endmodule

// File: rtl/step_ramp_chk.sv
module step_ramp_chk #(
  parameter int ACC_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             enable,
  input logic [ACC_W-1:0] offsetOut,
  input logic             stepStrobe,
  input logic             sweepDone
);

  a_r9_clear_on_stop: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> (offsetOut == '0 && !stepStrobe && !sweepDone))
    else $error("R9 offset or strobe not cleared after stop");

  a_r2_offset_moves_only_on_step: assert property (@(posedge clk) disable iff (!rstN)
    ($past(start) && !stepStrobe) |-> $stable(offsetOut))
    else $error("R2 offset changed without a step");

  a_r11_no_step_when_paused: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !stepStrobe)
    else $error("R11 step applied while paused");

  a_r4_done_with_step: assert property (@(posedge clk) disable iff (!rstN)
    sweepDone |-> stepStrobe)
    else $error("R4 sweep end flagged without a step");

endmodule

bind step_ramp_gen step_ramp_chk #(.ACC_W(ACC_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .enable(enable),
  .offsetOut(offsetOut), .stepStrobe(stepStrobe), .sweepDone(sweepDone)
);

// File: tb/test_step_ramp_gen.sv
module test_step_ramp_gen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgAddr = '0;
  logic [31:0] cfgData = '0;
  logic        start = 1'b0;
  logic        enable = 1'b1;
  logic [31:0] offsetOut;
  logic        stepStrobe;
  logic        sweepDone;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  step_ramp_gen i_step_ramp_gen (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .start(start), .enable(enable), .offsetOut(offsetOut),
    .stepStrobe(stepStrobe), .sweepDone(sweepDone)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic        dual;
    logic        fsk;
    logic [15:0] devA;
    logic [3:0]  shA;
    logic [19:0] nA;
    logic [15:0] devB;
    logic [3:0]  shB;
    logic [19:0] nB;
    logic [15:0] fskDev;
    logic [3:0]  fskSh;
    logic [11:0] div1;
    logic [11:0] div2;
    logic [31:0] e0, e1, e2, e3, e4, e5;
    logic [5:0]  doneMask;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    // R4 sawtooth, inc 5<<1 = 10, N=3
    '{2'd0, 1'b0, 1'b0, 16'd5, 4'd1, 20'd3, 16'd0, 4'd0, 20'd0, 16'd0, 4'd0, 12'd3, 12'd1,
      32'd10, 32'd20, 32'd30, 32'd0, 32'd10, 32'd20, 6'b001000},
    // R5 triangle, inc -3<<2 = -12, N=2
    '{2'd1, 1'b0, 1'b0, 16'hFFFD, 4'd2, 20'd2, 16'd0, 4'd0, 20'd0, 16'd0, 4'd0, 12'd2, 12'd2,
      32'hFFFFFFF4, 32'hFFFFFFE8, 32'hFFFFFFF4, 32'd0, 32'hFFFFFFF4, 32'hFFFFFFE8, 6'b001000},
    // R6 sawtooth two rates: A inc 4 x2, B inc 25<<2 = 100 x1
    '{2'd0, 1'b1, 1'b0, 16'd4, 4'd0, 20'd2, 16'd25, 4'd2, 20'd1, 16'd0, 4'd0, 12'd3, 12'd1,
      32'd4, 32'd8, 32'd108, 32'd0, 32'd4, 32'd8, 6'b001000},
    // R6 triangle two rates: A inc 7 x1, B inc 1 x2
    '{2'd1, 1'b1, 1'b0, 16'd7, 4'd0, 20'd1, 16'd1, 4'd0, 20'd2, 16'd0, 4'd0, 12'd3, 12'd1,
      32'd7, 32'd8, 32'd9, 32'd8, 32'd7, 32'd0, 6'b100000},
    // R7 FSK 1000 on alternate steps over a sawtooth of inc 3, N=5
    '{2'd0, 1'b0, 1'b1, 16'd3, 4'd0, 20'd5, 16'd0, 4'd0, 20'd0, 16'd1000, 4'd0, 12'd3, 12'd1,
      32'd1003, 32'd6, 32'd1009, 32'd12, 32'd1015, 32'd0, 6'b100000},
    // R8 and R3 positive clip: inc 0x7FFF<<15
    '{2'd0, 1'b0, 1'b0, 16'h7FFF, 4'd15, 20'd4, 16'd0, 4'd0, 20'd0, 16'd0, 4'd0, 12'd3, 12'd1,
      32'd1073709056, 32'd2147418112, 32'h7FFFFFFF, 32'h7FFFFFFF, 32'd0, 32'd1073709056,
      6'b010000},
    // R8 and R3 negative clip: inc -32768<<15
    '{2'd0, 1'b0, 1'b0, 16'h8000, 4'd15, 20'd4, 16'd0, 4'd0, 20'd0, 16'd0, 4'd0, 12'd3, 12'd1,
      32'hC0000000, 32'h80000000, 32'h80000000, 32'h80000000, 32'd0, 32'hC0000000, 6'b010000}
  };

  function automatic logic [31:0] expAt(input vec_t v, input int s);
    case (s)
      0: return v.e0;
      1: return v.e1;
      2: return v.e2;
      3: return v.e3;
      4: return v.e4;
      default: return v.e5;
    endcase
  endfunction

  function automatic string reqOf(input int i);
    case (i)
      0: return "R4";
      1: return "R5";
      2, 3: return "R6";
      4: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d (0x%08h) expected %0d (0x%08h)",
               req, what, $signed(act), act, $signed(exp), exp);
    end
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgWe = 1'b1;
    cfgAddr = a;
    cfgData = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic waitStrobe(input string req, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!stepStrobe && n < 2000);
    if (!stepStrobe) begin
      checks++;
      errors++;
      $display("FAIL %s step strobe: actual 0 expected 1", req);
    end
  endtask

  task automatic loadVec(input vec_t v);
    writeReg(3'd0, {12'd0, v.shA, v.devA});
    writeReg(3'd1, {12'd0, v.nA});
    writeReg(3'd2, {12'd0, v.shB, v.devB});
    writeReg(3'd3, {12'd0, v.nB});
    writeReg(3'd4, {4'd0, v.div2, 4'd0, v.div1});
    writeReg(3'd5, {28'd0, v.fsk, v.dual, v.mode});
    writeReg(3'd6, {12'd0, v.fskSh, v.fskDev});
  endtask

  task automatic setSimple(input logic [1:0] mode, input logic [15:0] dev,
                           input logic [19:0] n, input logic [11:0] d1,
                           input logic [11:0] d2);
    writeReg(3'd0, {16'd0, dev});
    writeReg(3'd1, {12'd0, n});
    writeReg(3'd4, {4'd0, d2, 4'd0, d1});
    writeReg(3'd5, {30'd0, mode});
    writeReg(3'd6, 32'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int n;
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1", "offset in reset", offsetOut, 32'd0);
    check("R1", "strobe in reset", {31'd0, stepStrobe}, 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "offset after reset", offsetOut, 32'd0);
    check("R1", "done after reset", {31'd0, sweepDone}, 32'd0);

    // Vector table: mode, rate and saturation sequences
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      start = 1'b0;
      loadVec(VECS[i]);
      @(negedge clk);
      start = 1'b1;
      for (int s = 0; s < 6; s++) begin
        waitStrobe(reqOf(i), n);
        check(reqOf(i), $sformatf("vec %0d step %0d offset", i, s),
              offsetOut, expAt(VECS[i], s));
        check(reqOf(i), $sformatf("vec %0d step %0d done", i, s),
              {31'd0, sweepDone}, {31'd0, VECS[i].doneMask[s]});
      end
    end

    // R2 step period: 3 x 2 = 6 cycles
    @(negedge clk);
    start = 1'b0;
    setSimple(2'd0, 16'd1, 20'd100, 12'd3, 12'd2);
    @(negedge clk);
    start = 1'b1;
    waitStrobe("R2", n);
    check("R2", "cycles to first step", n, 32'd7);
    check("R2", "first step value", offsetOut, 32'd1);
    waitStrobe("R2", n);
    check("R2", "cycles between steps", n, 32'd6);

    // R2 zero dividers act as one: a step every cycle
    @(negedge clk);
    start = 1'b0;
    setSimple(2'd0, 16'd1, 20'd100, 12'd0, 12'd0);
    @(negedge clk);
    start = 1'b1;
    waitStrobe("R2", n);
    check("R2", "cycles to first step, period 1", n, 32'd2);
    @(negedge clk);
    check("R2", "strobe every cycle, period 1", {31'd0, stepStrobe}, 32'd1);
    check("R2", "offset after two steps", offsetOut, 32'd2);

    // R9 stop clears on the next clock
    start = 1'b0;
    @(negedge clk);
    check("R9", "offset after stop", offsetOut, 32'd0);
    check("R9", "strobe after stop", {31'd0, stepStrobe}, 32'd0);

    // R10 shadowed write applies at sweep end
    setSimple(2'd0, 16'd1, 20'd3, 12'd10, 12'd1);
    @(negedge clk);
    start = 1'b1;
    waitStrobe("R10", n);
    check("R10", "step 1 value", offsetOut, 32'd1);
    writeReg(3'd0, 32'd50);
    waitStrobe("R10", n);
    check("R10", "step 2 keeps old increment", offsetOut, 32'd2);
    waitStrobe("R10", n);
    check("R10", "step 3 keeps old increment", offsetOut, 32'd3);
    waitStrobe("R10", n);
    check("R10", "return step", offsetOut, 32'd0);
    waitStrobe("R10", n);
    check("R10", "new increment next sweep", offsetOut, 32'd50);

    // R11 pause holds the offset and the sweep position
    @(negedge clk);
    enable = 1'b0;
    begin
      int strobes = 0;
      int moved = 0;
      for (int k = 0; k < 30; k++) begin
        @(negedge clk);
        if (stepStrobe) strobes++;
        if (offsetOut !== 32'd50) moved++;
      end
      check("R11", "strobes while paused", strobes, 32'd0);
      check("R11", "offset changes while paused", moved, 32'd0);
    end
    enable = 1'b1;
    waitStrobe("R11", n);
    check("R11", "resume continues sweep", offsetOut, 32'd100);

    // R12 hold mode
    @(negedge clk);
    start = 1'b0;
    setSimple(2'd2, 16'd9, 20'd3, 12'd2, 12'd1);
    @(negedge clk);
    start = 1'b1;
    begin
      int strobes = 0;
      int nonzero = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (stepStrobe) strobes++;
        if (offsetOut !== 32'd0) nonzero++;
      end
      check("R12", "strobes in hold mode", strobes, 32'd0);
      check("R12", "nonzero offsets in hold mode", nonzero, 32'd0);
    end
    start = 1'b0;
    @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule